// File: doc/BRIEF.md
# Mode-Selectable Synchronous Clock Ratio Tree

This block takes one fast master clock and derives five aligned clock levels from it: a CPU clock, a half-CPU memory reference clock, a 66 MHz-class clock, a PCI-class clock and an interrupt-controller clock. All ratios are integer, and all of them come from a single shared phase counter. Every domain therefore rises on the same master edge at the start of the common period. A frequency-family select picks between the 133 family (ratios 2/4/4/8/16 of the master clock) and the 100 family (ratios 2/4/3/6/12). In both families the master clock runs at twice the CPU rate.

A three-bit mode code `{sel_fast, sel_mode[1], sel_mode[0]}` chooses the mode. The block can run normally with or without the USB clock enable. It can disable every output, which models three-state drive through output-enable flags. It can also run a test mode in which a slow external test clock, sampled by the master clock, steps the divider. In test mode the test clock itself is passed out on the reference output. Any change of the mode code restarts the phase counter, so all domains realign at once.

Top module: `clk_ratio_tree`

## Requirements
- R1: While `rst` is high on a master rising edge, every clock output and both output enables are 0 after that edge.
- R2: Codes 000, 001 and 101 disable everything. After one master edge the output enables `core_oe` and `usb_oe` are 0, all seven clock outputs are 0, and the phase counter is held at its start.
- R3: Output enables: codes 010 and 110 give `core_oe`=1 and `usb_oe`=0. Codes 011, 111 and test code 100 give `core_oe`=1 and `usb_oe`=1.
- R4: With `sel_fast`=1 in a run code, the outputs repeat with periods of 2 (CPU), 4 (memory), 4 (66), 8 (PCI) and 16 (interrupt) master cycles.
- R5: With `sel_fast`=0 in a run code, the periods are 2, 4, 3, 6 and 12 master cycles.
- R6: A domain with ratio N is high in the first ceil(N/2) master cycles of its period and low in the rest, so a ratio-3 domain runs high, high, low.
- R7: A new mode code is latched on the next master edge and the phase counter restarts at 0. After the following edge all five domain clocks are high together. The interrupt clock never rises unless all other domains are high.
- R8: In code 100 the phase counter advances once per rising edge of `test_clk`, sampled through two master-clock registers. Counted in test-clock rising edges, the ratios are CPU 2, memory 4, 66 4, PCI 8, interrupt 16 and USB 2. `ref_clk` equals `test_clk` as it stood two master edges earlier.
- R9: Outside code 100, `usb_clk` and `ref_clk` are held at 0 and `test_clk` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the CPU rate |
| rst | input | 1 | Synchronous active-high reset |
| sel_fast | input | 1 | Family select: 1 = 133 family, 0 = 100 family; mode code bit 2 |
| sel_mode | input | 2 | Mode code bits 1:0 |
| test_clk | input | 1 | External test clock, slower than the master clock |
| cpu_clk | output | 1 | CPU domain clock level |
| mem_clk | output | 1 | Half-CPU memory reference clock level |
| m66_clk | output | 1 | 66 MHz-class clock level |
| pci_clk | output | 1 | PCI-class clock level |
| apic_clk | output | 1 | Interrupt-controller clock level |
| usb_clk | output | 1 | USB clock level, driven only in test mode |
| ref_clk | output | 1 | Reference clock level, driven only in test mode |
| core_oe | output | 1 | Drive enable for the CPU, memory, 66, PCI, interrupt and reference outputs |
| usb_oe | output | 1 | Drive enable for the USB output |

## Verification
The assertions assume that `test_clk` stays at each level for at least two master cycles, so that the two-stage sampler sees every rising edge once. They also assume that the mode code is held steady for at least one full master cycle at a time. The bench drives `test_clk` from the falling master edge with a random half-period of two to five master cycles. It changes the mode code only on the falling master edge and holds each code for many cycles. Both inputs therefore stay inside these limits, including during random code changes that land at any phase of the counter.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_TEST    = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_RUN_USB = 2'd3
  } tree_mode_e;

  localparam int unsigned NUM_DOM = 5;

  // code bit order: {family select, mode bit 1, mode bit 0}
  function automatic tree_mode_e decode_mode(input logic [2:0] code);
    tree_mode_e m;
    case (code)
      3'b100:        m = MODE_TEST;
      3'b010, 3'b110: m = MODE_RUN;
      3'b011, 3'b111: m = MODE_RUN_USB;
      default:       m = MODE_OFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/clk_ratio_tsync.sv
module clk_ratio_tsync (
  input  logic clk,
  input  logic rst,
  input  logic tclk_i,
  output logic lvl_o,
  output logic rise_o
);

  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= tclk_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o  = s1_q;
  assign rise_o = s1_q & ~s2_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R8

endmodule

// File: rtl/clk_ratio_phase.sv
module clk_ratio_phase
  import clk_ratio_pkg::*;
#(
  parameter int unsigned PH_W  = 4,
  parameter int unsigned PER_F = 16,
  parameter int unsigned PER_S = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      code_i,
  input  logic            step_i,
  output logic [2:0]      mode_q,
  output logic [PH_W-1:0] phase_q
);

  tree_mode_e      mode_d;
  logic            advance;
  logic [PH_W-1:0] last;

  assign mode_d  = decode_mode(mode_q);
  assign advance = (mode_d == MODE_RUN) || (mode_d == MODE_RUN_USB) ||
                   ((mode_d == MODE_TEST) && step_i);
  assign last    = mode_q[2] ? PH_W'(PER_F - 1) : PH_W'(PER_S - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 3'b000;
      phase_q <= '0;
    end else if (code_i != mode_q) begin
      mode_q  <= code_i;
      phase_q <= '0;
    end else if (advance) begin
      phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    phase_q <= last); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (code_i != mode_q) |=> (phase_q == '0) && (mode_q == $past(code_i))); // R7

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mode_d == MODE_OFF) |-> (phase_q == '0)); // R2

endmodule

// File: rtl/clk_ratio_tap.sv
module clk_ratio_tap #(
  parameter int unsigned PH_W  = 4,
  parameter int unsigned DIV_F = 4,
  parameter int unsigned DIV_S = 3
) (
  input  logic            fast_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            lvl_o
);

  int unsigned rem_f, rem_s;

  assign rem_f = 32'(phase_i) % DIV_F;
  assign rem_s = 32'(phase_i) % DIV_S;
  // high for the first ceil(N/2) steps of each period
  assign lvl_o = fast_i ? (2 * rem_f < DIV_F) : (2 * rem_s < DIV_S);

endmodule

// File: rtl/clk_ratio_tree.sv
module clk_ratio_tree
  import clk_ratio_pkg::*;
#(
  parameter int unsigned CPU_DIV    = 2,
  parameter int unsigned MEM_DIV    = 4,
  parameter int unsigned M66_DIV_F  = 4,
  parameter int unsigned M66_DIV_S  = 3,
  parameter int unsigned PCI_DIV_F  = 8,
  parameter int unsigned PCI_DIV_S  = 6,
  parameter int unsigned APIC_DIV_F = 16,
  parameter int unsigned APIC_DIV_S = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_fast,
  input  logic [1:0] sel_mode,
  input  logic       test_clk,
  output logic       cpu_clk,
  output logic       mem_clk,
  output logic       m66_clk,
  output logic       pci_clk,
  output logic       apic_clk,
  output logic       usb_clk,
  output logic       ref_clk,
  output logic       core_oe,
  output logic       usb_oe
);

  localparam int unsigned PER_MAX = (APIC_DIV_F > APIC_DIV_S) ? APIC_DIV_F : APIC_DIV_S;
  localparam int unsigned PH_W    = (PER_MAX > 2) ? $clog2(PER_MAX) : 1;
  localparam int unsigned DIVS_F [NUM_DOM] = '{CPU_DIV, MEM_DIV, M66_DIV_F, PCI_DIV_F, APIC_DIV_F};
  localparam int unsigned DIVS_S [NUM_DOM] = '{CPU_DIV, MEM_DIV, M66_DIV_S, PCI_DIV_S, APIC_DIV_S};

  logic [2:0]         mode_q;
  logic [PH_W-1:0]    phase_q;
  logic               t_lvl, t_rise;
  logic [NUM_DOM-1:0] lvl;
  logic [NUM_DOM-1:0] dom_q;
  logic               usb_q, ref_q, core_oe_q, usb_oe_q;
  tree_mode_e         mode_d;

  clk_ratio_tsync u_tsync (
    .clk    (clk),
    .rst    (rst),
    .tclk_i (test_clk),
    .lvl_o  (t_lvl),
    .rise_o (t_rise)
  );

  clk_ratio_phase #(
    .PH_W  (PH_W),
    .PER_F (APIC_DIV_F),
    .PER_S (APIC_DIV_S)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .code_i  ({sel_fast, sel_mode}),
    .step_i  (t_rise),
    .mode_q  (mode_q),
    .phase_q (phase_q)
  );

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_tap
    clk_ratio_tap #(
      .PH_W  (PH_W),
      .DIV_F (DIVS_F[g]),
      .DIV_S (DIVS_S[g])
    ) u_tap (
      .fast_i  (mode_q[2]),
      .phase_i (phase_q),
      .lvl_o   (lvl[g])
    );
  end

  assign mode_d = decode_mode(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_q     <= '0;
      usb_q     <= 1'b0;
      ref_q     <= 1'b0;
      core_oe_q <= 1'b0;
      usb_oe_q  <= 1'b0;
    end else begin
      case (mode_d)
        MODE_TEST: begin
          dom_q     <= lvl;
          usb_q     <= lvl[0];
          ref_q     <= t_lvl;
          core_oe_q <= 1'b1;
          usb_oe_q  <= 1'b1;
        end
        MODE_RUN, MODE_RUN_USB: begin
          dom_q     <= lvl;
          usb_q     <= 1'b0;
          ref_q     <= 1'b0;
          core_oe_q <= 1'b1;
          usb_oe_q  <= (mode_d == MODE_RUN_USB);
        end
        default: begin
          dom_q     <= '0;
          usb_q     <= 1'b0;
          ref_q     <= 1'b0;
          core_oe_q <= 1'b0;
          usb_oe_q  <= 1'b0;
        end
      endcase
    end
  end

  assign cpu_clk  = dom_q[0];
  assign mem_clk  = dom_q[1];
  assign m66_clk  = dom_q[2];
  assign pci_clk  = dom_q[3];
  assign apic_clk = dom_q[4];
  assign usb_clk  = usb_q;
  assign ref_clk  = ref_q;
  assign core_oe  = core_oe_q;
  assign usb_oe   = usb_oe_q;

  // checker state: a run mode held across one edge without restart
  logic [2:0] mode_prev_q;
  logic       steady_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_prev_q <= 3'b000;
      steady_q    <= 1'b0;
    end else begin
      mode_prev_q <= mode_q;
      steady_q    <= ((mode_d == MODE_RUN) || (mode_d == MODE_RUN_USB)) &&
                     (mode_q == mode_prev_q);
    end
  end

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !core_oe |-> (dom_q == '0) && !usb_clk && !ref_clk && !usb_oe); // R2

  AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(apic_clk) |-> cpu_clk && mem_clk && m66_clk && pci_clk); // R7

  AST_CPU_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    steady_q |-> (cpu_clk != $past(cpu_clk))); // R4

  AST_USB_NEEDS_CORE: assert property (@(posedge clk) disable iff (rst)
    usb_oe |-> core_oe); // R3

endmodule

// File: tb/clk_ratio_tree_tb.sv
module clk_ratio_tree_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       sel_fast;
  logic [1:0] sel_mode;
  logic       test_clk;
  logic       cpu_clk, mem_clk, m66_clk, pci_clk, apic_clk;
  logic       usb_clk, ref_clk, core_oe, usb_oe;

  always #10 clk = ~clk;

  clk_ratio_tree dut_i (
    .clk      (clk),
    .rst      (rst),
    .sel_fast (sel_fast),
    .sel_mode (sel_mode),
    .test_clk (test_clk),
    .cpu_clk  (cpu_clk),
    .mem_clk  (mem_clk),
    .m66_clk  (m66_clk),
    .pci_clk  (pci_clk),
    .apic_clk (apic_clk),
    .usb_clk  (usb_clk),
    .ref_clk  (ref_clk),
    .core_oe  (core_oe),
    .usb_oe   (usb_oe)
  );

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // packing: {core_oe, usb_oe, ref, usb, apic, pci, m66, mem, cpu}
  function automatic logic [8:0] got_vec();
    return {core_oe, usb_oe, ref_clk, usb_clk, apic_clk, pci_clk, m66_clk, mem_clk, cpu_clk};
  endfunction

  function automatic logic lv(int unsigned p, int unsigned n);
    return (2 * (p % n)) < n;
  endfunction

  function automatic logic [4:0] doms(logic fast, int unsigned p);
    logic [4:0] d;
    if (fast) d = {lv(p, 16), lv(p, 8), lv(p, 4), lv(p, 4), lv(p, 2)};
    else      d = {lv(p, 12), lv(p, 6), lv(p, 3), lv(p, 4), lv(p, 2)};
    return d;
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // independent model of the requirements
  logic [2:0]  m_mode;
  int unsigned m_phase;
  logic        m_t1, m_t2;
  logic [8:0]  e_vec;
  string       e_tag;

  always @(posedge clk) begin
    logic adv;
    int unsigned per;
    if (rst) begin
      m_mode = 3'b000; m_phase = 0; m_t1 = 1'b0; m_t2 = 1'b0;
      e_vec = '0; e_tag = "R1";
    end else begin
      case (m_mode)
        3'b100: begin
          e_vec = {1'b1, 1'b1, m_t1, lv(m_phase, 2), doms(1'b1, m_phase)};
          e_tag = "R8";
        end
        3'b010, 3'b110: begin
          e_vec = {1'b1, 1'b0, 1'b0, 1'b0, doms(m_mode[2], m_phase)};
          e_tag = m_mode[2] ? "R4" : "R5";
        end
        3'b011, 3'b111: begin
          e_vec = {1'b1, 1'b1, 1'b0, 1'b0, doms(m_mode[2], m_phase)};
          e_tag = m_mode[2] ? "R4" : "R5";
        end
        default: begin
          e_vec = '0;
          e_tag = "R2";
        end
      endcase
      adv = (m_mode[1] == 1'b1) || ((m_mode == 3'b100) && m_t1 && !m_t2);
      per = m_mode[2] ? 16 : 12;
      if ({sel_fast, sel_mode} != m_mode) begin
        m_mode = {sel_fast, sel_mode}; m_phase = 0;
      end else if (adv) begin
        m_phase = (m_phase == per - 1) ? 0 : m_phase + 1;
      end
      m_t2 = m_t1;
      m_t1 = test_clk;
    end
  end

  always @(negedge clk) begin
    if (!done && e_tag.len() != 0) begin
      logic [8:0] g;
      string t;
      g = got_vec();
      t = e_tag;
      if (g[8:7] !== e_vec[8:7]) t = "R3";
      else if (g[6:5] !== e_vec[6:5] && e_tag != "R8") t = "R9";
      chk(t, g, e_vec);
    end
  end

  // test clock with random half-period of 2..5 master cycles
  initial begin
    int cnt;
    test_clk = 1'b0;
    cnt = 2;
    forever begin
      @(negedge clk);
      if (cnt <= 1) begin
        test_clk = ~test_clk;
        cnt = 2 + int'($urandom % 4);
      end else cnt--;
    end
  end

  task automatic hold(input logic [2:0] code, input int n);
    @(negedge clk);
    {sel_fast, sel_mode} = code;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    logic [8:0] g;
    void'($urandom(32'd1234));
    rst = 1'b1;
    {sel_fast, sel_mode} = 3'b000;
    repeat (3) @(negedge clk);
    chk("R1", got_vec(), 9'b0);                     // R1 reset state
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R7 / R6: switch to 100 family without USB, check restart and ratio-3 duty
    {sel_fast, sel_mode} = 3'b010;
    @(negedge clk);
    @(negedge clk);
    chk("R7", got_vec(), 9'b1_0_0_0_11111);          // all domains high at phase 0
    @(negedge clk);
    g = got_vec();
    chk("R6", {8'b0, g[2]}, 9'd1);                   // ratio 3: second step high
    @(negedge clk);
    g = got_vec();
    chk("R6", {8'b0, g[2]}, 9'd0);                   // third step low
    @(negedge clk);
    g = got_vec();
    chk("R6", {8'b0, g[2]}, 9'd1);                   // next period rises

    // directed sweep of every code
    hold(3'b000, 30);
    hold(3'b001, 30);
    hold(3'b101, 30);
    hold(3'b100, 200);
    hold(3'b110, 40);
    g = got_vec();
    chk("R9", {7'b0, g[6:5]}, 9'b0);                 // R9 no test clock leak
    hold(3'b111, 40);
    hold(3'b011, 40);
    hold(3'b010, 40);

    // mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", got_vec(), 9'b0);
    rst = 1'b0;

    // constrained random code sequences
    for (int k = 0; k < 40; k++) begin
      hold(3'($urandom % 8), 10 + int'($urandom % 80));
    end
    hold(3'b100, 150);
    hold(3'b000, 5);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule